// File: doc/BRIEF.md
# PLL divider and lock monitor

This block is the digital half of a clock-multiplying phase-locked loop. It produces a reference timing strobe by dividing the oscillator clock by a programmable integer. It produces a feedback clock by dividing the externally supplied VCO clock by a programmable even integer. It also passes the VCO clock to the output, either directly or halved. The analog loop (phase comparison, charge pump, filter, oscillator) lies outside the block. The test environment supplies the VCO clock as a stimulus.

A frequency-comparison lock monitor counts feedback clock rising edges over windows of reference periods. It declares the loop locked after a run of windows whose counts are close to the expected value. It drops lock when a single window is far off. The feedback edge count is kept as a gray-coded counter in the VCO domain and is resynchronized into the oscillator domain. The lock state is presented as a read-only status output. A sticky lock-change interrupt flag, gated by an enable and cleared by a pulse, lets software either wait for a change or poll the status.

Top module: `pll_divlock_mon`

## Requirements
- R1: `ref_tick_o` is a one-cycle-high strobe in the oscillator domain with a period of `ref_div_i`+1 oscillator cycles, where the value is the one latched by `div_wr_i`. With a divider value of 0 the strobe is high on every cycle after reset. It is low while reset is held.
- R2: `fb_clk_o` is a square wave with a period of 2×(`syn_div_i`+1) VCO cycles. It is high for half of that period and low for the other half. It is low while reset is held.
- R3: `pll_clk_o` runs at the VCO frequency when the latched post-divide bit is 0, and at half the VCO frequency when it is 1.
- R4: One window lasts WIN_LEN (default 32) reference strobes. The first window after reset or after a divider write is discarded. `lock_o` rises at the end of the LOCK_WINS-th (default 4) consecutive window whose feedback edge count lies within WIN_LEN±TOL_IN (default ±1).
- R5: While locked, a single window whose count lies outside WIN_LEN±TOL_OUT (default ±2) clears `lock_o` at the end of that window.
- R6: While locked, windows whose count stays within WIN_LEN±TOL_OUT keep `lock_o` high.
- R7: `irq_o` is set one cycle after any change of `lock_o` if the latched interrupt enable is 1. It then holds until an `irq_clr_i` pulse. If set and clear occur in the same cycle, set wins. With the enable at 0, lock changes leave `irq_o` at 0.
- R8: A `div_wr_i` pulse clears `lock_o` at the next clock edge and restarts qualification. A `ctl_wr_i` pulse alone leaves `lock_o` unchanged.
- R9: A new reference divider value takes effect only at the next terminal count. The interval that is running when the value is written completes with the old ratio.
- R10: The feedback edge count crosses into the oscillator domain as a gray code. Between consecutive VCO cycles at most one bit of the code changes, and the code changes on each rising edge of the feedback clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | Oscillator clock; also clocks the register inputs and the lock monitor |
| rst_i | input | 1 | Synchronous active-high reset (oscillator domain, resynchronized into the VCO domain) |
| vco_clk_i | input | 1 | VCO clock from the analog loop |
| div_wr_i | input | 1 | Latches both divider fields and restarts lock qualification |
| ref_div_i | input | 6 | Reference divider value N, ratio N+1 |
| syn_div_i | input | 6 | Loop divider value M, ratio 2×(M+1) |
| ctl_wr_i | input | 1 | Latches the post-divide bit and the interrupt enable |
| post_div2_i | input | 1 | 1 selects VCO/2 as the output clock |
| irq_en_i | input | 1 | Lock-change interrupt enable |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| ref_tick_o | output | 1 | Reference strobe |
| fb_clk_o | output | 1 | Feedback clock |
| pll_clk_o | output | 1 | Output clock, VCO or VCO/2 |
| lock_o | output | 1 | Lock status |
| irq_o | output | 1 | Sticky lock-change interrupt flag |

## Verification
The bench builds the block with its default parameters: a 32-strobe window, 4 qualifying windows, tolerances of ±1 to acquire and ±2 to hold, and an 8-bit gray counter. The bench runs reference ratios of 1, 2 and 4 against loop ratios of 2 and 4. It tunes the VCO period so that a window counts exactly 32, about 31, or about 21 feedback edges. These values keep a full acquisition within a few hundred oscillator cycles. They also reach the hold-band case, the far-off drop and the mid-interval divider change.

// File: rtl/pll_mon_pkg.sv
package pll_mon_pkg;

  localparam int unsigned DIV_W = 6;

  typedef struct packed {
    logic [DIV_W-1:0] ref_div;
    logic [DIV_W-1:0] syn_div;
  } div_cfg_t;

  typedef struct packed {
    logic post_div2;
    logic irq_en;
  } ctl_cfg_t;

endpackage

// File: rtl/pllm_ref_div.sv
module pllm_ref_div #(
  parameter int unsigned DIV_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_q;
  logic             tick_q;
  logic             term;

  assign term = (cnt_q == div_q);

  // the active ratio is reloaded only at terminal count
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= '0;
      div_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= term;
      if (term) begin
        cnt_q <= '0;
        div_q <= div_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign tick_o = tick_q;

  AST_REF_TICK_SPACING: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick_q && div_q != '0) |=> !tick_q); // R1

endmodule

// File: rtl/pllm_fb_div.sv
module pllm_fb_div #(
  parameter int unsigned DIV_W = 6,
  parameter int unsigned CNT_W = 8
) (
  input  logic             vco_clk_i,
  input  logic             rst_i,
  input  logic [DIV_W-1:0] syn_div_i,
  input  logic             post_div2_i,
  output logic             fb_clk_o,
  output logic             pll_clk_o,
  output logic [CNT_W-1:0] fb_gray_o
);

  logic [1:0]       rst_pipe_q;
  logic             rst_v;
  logic [DIV_W-1:0] syn_meta_q, syn_sync_q;
  logic             d2_meta_q, d2_sync_q;
  logic [DIV_W-1:0] cnt_q, act_q;
  logic             fb_q, half_q, sel_q;
  logic [CNT_W-1:0] bin_q, gray_q, bin_nxt;
  logic             term;

  always_ff @(posedge vco_clk_i) begin
    rst_pipe_q <= {rst_pipe_q[0], rst_i};
    syn_meta_q <= syn_div_i;
    syn_sync_q <= syn_meta_q;
    d2_meta_q  <= post_div2_i;
    d2_sync_q  <= d2_meta_q;
  end

  assign rst_v   = rst_pipe_q[1];
  assign term    = (cnt_q == act_q);
  assign bin_nxt = bin_q + 1'b1;

  always_ff @(posedge vco_clk_i) begin
    if (rst_v) begin
      cnt_q  <= '0;
      act_q  <= '0;
      fb_q   <= 1'b0;
      half_q <= 1'b0;
      sel_q  <= 1'b0;
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      half_q <= ~half_q;
      sel_q  <= d2_sync_q;
      if (term) begin
        cnt_q <= '0;
        fb_q  <= ~fb_q;
        if (fb_q) begin
          act_q <= syn_sync_q;
        end else begin
          bin_q  <= bin_nxt;
          gray_q <= bin_nxt ^ (bin_nxt >> 1);
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign fb_clk_o  = fb_q;
  assign fb_gray_o = gray_q;
  assign pll_clk_o = sel_q ? half_q : vco_clk_i;

  AST_GRAY_ONE_STEP: assert property (@(posedge vco_clk_i) disable iff (rst_v)
    $countones(gray_q ^ $past(gray_q)) <= 1); // R10

  AST_GRAY_ON_FB_RISE: assert property (@(posedge vco_clk_i) disable iff (rst_v)
    $rose(fb_q) |-> (gray_q != $past(gray_q))); // R10

endmodule

// File: rtl/pllm_lock_det.sv
module pllm_lock_det #(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned WIN_LEN   = 32,
  parameter int unsigned LOCK_WINS = 4,
  parameter int unsigned TOL_IN    = 1,
  parameter int unsigned TOL_OUT   = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             ref_tick_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] fb_gray_i,
  input  logic             irq_en_i,
  input  logic             irq_clr_i,
  output logic             lock_o,
  output logic             irq_o
);

  localparam int unsigned WIN_W = $clog2(WIN_LEN);
  localparam int unsigned STK_W = $clog2(LOCK_WINS + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_LEN - 1);
  localparam logic [STK_W-1:0] STK_LAST = STK_W'(LOCK_WINS - 1);
  localparam logic [CNT_W-1:0] IN_LO  = CNT_W'(WIN_LEN - TOL_IN);
  localparam logic [CNT_W-1:0] IN_HI  = CNT_W'(WIN_LEN + TOL_IN);
  localparam logic [CNT_W-1:0] OUT_LO = CNT_W'(WIN_LEN - TOL_OUT);
  localparam logic [CNT_W-1:0] OUT_HI = CNT_W'(WIN_LEN + TOL_OUT);

  logic [CNT_W-1:0] g_meta_q, g_sync_q, bin_s, snap_q, delta;
  logic [WIN_W-1:0] win_q;
  logic [STK_W-1:0] streak_q;
  logic             primed_q, lock_q, lock_prev_q, irq_q;
  logic             win_end, eval, in_win, out_win;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      g_meta_q <= '0;
      g_sync_q <= '0;
    end else begin
      g_meta_q <= fb_gray_i;
      g_sync_q <= g_meta_q;
    end
  end

  always_comb begin
    bin_s[CNT_W-1] = g_sync_q[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) begin
      bin_s[i] = bin_s[i+1] ^ g_sync_q[i];
    end
  end

  assign delta   = bin_s - snap_q;
  assign win_end = ref_tick_i && (win_q == WIN_LAST);
  assign eval    = win_end && primed_q && !restart_i;
  assign in_win  = (delta >= IN_LO) && (delta <= IN_HI);
  assign out_win = (delta < OUT_LO) || (delta > OUT_HI);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      win_q    <= '0;
      snap_q   <= '0;
      primed_q <= 1'b0;
      streak_q <= '0;
      lock_q   <= 1'b0;
    end else if (restart_i) begin
      win_q    <= '0;
      primed_q <= 1'b0;
      streak_q <= '0;
      lock_q   <= 1'b0;
    end else if (win_end) begin
      win_q    <= '0;
      snap_q   <= bin_s;
      primed_q <= 1'b1;
      if (eval) begin
        if (lock_q) begin
          if (out_win) lock_q <= 1'b0;
        end else if (in_win) begin
          if (streak_q == STK_LAST) begin
            lock_q   <= 1'b1;
            streak_q <= '0;
          end else begin
            streak_q <= streak_q + 1'b1;
          end
        end else begin
          streak_q <= '0;
        end
      end
    end else if (ref_tick_i) begin
      win_q <= win_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      lock_prev_q <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      lock_prev_q <= lock_q;
      if ((lock_q != lock_prev_q) && irq_en_i) irq_q <= 1'b1;
      else if (irq_clr_i)                      irq_q <= 1'b0;
    end
  end

  assign lock_o = lock_q;
  assign irq_o  = irq_q;

  AST_LOCK_AFTER_STREAK: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(lock_q) |-> ($past(streak_q) == STK_LAST && $past(eval) && $past(in_win))); // R4

  AST_DROP_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(lock_q) |-> ($past(restart_i) || ($past(eval) && $past(out_win)))); // R5

  AST_RESTART_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
    restart_i |=> !lock_q); // R8

  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
    (irq_q && !irq_clr_i) |=> irq_q); // R7

  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
    (!irq_q && !irq_en_i) |=> !irq_q); // R7

endmodule

// File: rtl/pll_divlock_mon.sv
module pll_divlock_mon
  import pll_mon_pkg::*;
#(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned WIN_LEN   = 32,
  parameter int unsigned LOCK_WINS = 4,
  parameter int unsigned TOL_IN    = 1,
  parameter int unsigned TOL_OUT   = 2
) (
  input  logic             osc_clk_i,
  input  logic             rst_i,
  input  logic             vco_clk_i,
  input  logic             div_wr_i,
  input  logic [DIV_W-1:0] ref_div_i,
  input  logic [DIV_W-1:0] syn_div_i,
  input  logic             ctl_wr_i,
  input  logic             post_div2_i,
  input  logic             irq_en_i,
  input  logic             irq_clr_i,
  output logic             ref_tick_o,
  output logic             fb_clk_o,
  output logic             pll_clk_o,
  output logic             lock_o,
  output logic             irq_o
);

  div_cfg_t         div_q;
  ctl_cfg_t         ctl_q;
  logic [CNT_W-1:0] fb_gray;
  logic             ref_tick;

  always_ff @(posedge osc_clk_i) begin
    if (rst_i) begin
      div_q <= '0;
      ctl_q <= '0;
    end else begin
      if (div_wr_i) div_q <= '{ref_div: ref_div_i, syn_div: syn_div_i};
      if (ctl_wr_i) ctl_q <= '{post_div2: post_div2_i, irq_en: irq_en_i};
    end
  end

  pllm_ref_div #(.DIV_W(DIV_W)) u_ref_div (
    .clk_i  (osc_clk_i),
    .rst_i  (rst_i),
    .div_i  (div_q.ref_div),
    .tick_o (ref_tick)
  );

  pllm_fb_div #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_fb_div (
    .vco_clk_i   (vco_clk_i),
    .rst_i       (rst_i),
    .syn_div_i   (div_q.syn_div),
    .post_div2_i (ctl_q.post_div2),
    .fb_clk_o    (fb_clk_o),
    .pll_clk_o   (pll_clk_o),
    .fb_gray_o   (fb_gray)
  );

  pllm_lock_det #(
    .CNT_W(CNT_W), .WIN_LEN(WIN_LEN), .LOCK_WINS(LOCK_WINS),
    .TOL_IN(TOL_IN), .TOL_OUT(TOL_OUT)
  ) u_lock_det (
    .clk_i      (osc_clk_i),
    .rst_i      (rst_i),
    .ref_tick_i (ref_tick),
    .restart_i  (div_wr_i),
    .fb_gray_i  (fb_gray),
    .irq_en_i   (ctl_q.irq_en),
    .irq_clr_i  (irq_clr_i),
    .lock_o     (lock_o),
    .irq_o      (irq_o)
  );

  assign ref_tick_o = ref_tick;

  AST_CTL_KEEPS_DIV: assert property (@(posedge osc_clk_i) disable iff (rst_i)
    (ctl_wr_i && !div_wr_i) |=> (div_q == $past(div_q))); // R8

endmodule

// File: tb/test_pll_divlock_mon.sv
`timescale 1ns/1ps
module test_pll_divlock_mon;

  logic osc_clk = 1'b0;
  logic vco_clk = 1'b0;
  logic rst = 1'b1;
  logic div_wr = 1'b0, ctl_wr = 1'b0, post_div2 = 1'b0, irq_en = 1'b0, irq_clr = 1'b0;
  logic [5:0] ref_div = '0, syn_div = '0;
  logic ref_tick, fb_clk, pll_clk, lock, irq;
  real  vco_half = 5.0;
  longint cyc = 0;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #10 osc_clk = ~osc_clk;
  always begin #(vco_half); vco_clk = ~vco_clk; end

  pll_divlock_mon i_pll_divlock_mon (
    .osc_clk_i(osc_clk), .rst_i(rst), .vco_clk_i(vco_clk),
    .div_wr_i(div_wr), .ref_div_i(ref_div), .syn_div_i(syn_div),
    .ctl_wr_i(ctl_wr), .post_div2_i(post_div2), .irq_en_i(irq_en), .irq_clr_i(irq_clr),
    .ref_tick_o(ref_tick), .fb_clk_o(fb_clk), .pll_clk_o(pll_clk),
    .lock_o(lock), .irq_o(irq)
  );

  typedef struct {
    longint at;
    logic   exp_lock;
    logic   chk_irq;
    logic   exp_irq;
    string  req;
  } exp_t;
  exp_t sb_q[$];
  exp_t cur;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: compares lock/irq against queued expectations
  always @(negedge osc_clk) begin
    cyc++;
    while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
      cur = sb_q.pop_front();
      check(cur.req, "lock_o", longint'(lock), longint'(cur.exp_lock));
      if (cur.chk_irq) check(cur.req, "irq_o", longint'(irq), longint'(cur.exp_irq));
    end
  end

  task automatic expect_at(input longint dly, input logic lk, input logic ci, input logic ir, input string req);
    exp_t e;
    e.at = cyc + dly; e.exp_lock = lk; e.chk_irq = ci; e.exp_irq = ir; e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge osc_clk);
    #5;
  endtask

  task automatic drain();
    while (sb_q.size() > 0) tick(1);
  endtask

  task automatic div_write(input logic [5:0] r, input logic [5:0] s);
    ref_div = r; syn_div = s; div_wr = 1'b1;
    tick(1);
    div_wr = 1'b0;
  endtask

  task automatic ctl_write(input logic d2, input logic en);
    post_div2 = d2; irq_en = en; ctl_wr = 1'b1;
    tick(1);
    ctl_wr = 1'b0;
  endtask

  task automatic clear_irq();
    irq_clr = 1'b1;
    tick(1);
    irq_clr = 1'b0;
  endtask

  task automatic ref_interval(output int n);
    n = 0;
    do begin tick(1); n++; end while (!ref_tick);
  endtask

  task automatic fb_ratio(input string req, input int exp);
    realtime t1, t2, t3;
    @(posedge fb_clk); t1 = $realtime;
    @(negedge fb_clk); t2 = $realtime;
    @(posedge fb_clk); t3 = $realtime;
    check(req, "fb period in VCO cycles", longint'($rtoi((t3 - t1) / (2.0 * vco_half) + 0.5)), exp);
    check(req, "fb high time in VCO cycles", longint'($rtoi((t2 - t1) / (2.0 * vco_half) + 0.5)), exp / 2);
    tick(1);
  endtask

  task automatic pll_period(input string req, input int exp_ns);
    realtime t1, t2;
    @(posedge pll_clk); t1 = $realtime;
    @(posedge pll_clk); t2 = $realtime;
    check(req, "pll period ns", longint'($rtoi(t2 - t1 + 0.5)), exp_ns);
    tick(1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    tick(10);
    // reset state
    check("R1", "ref_tick in reset", ref_tick, 0);
    check("R2", "fb_clk in reset", fb_clk, 0);
    check("R4", "lock in reset", lock, 0);
    check("R7", "irq in reset", irq, 0);
    rst = 1'b0;
    tick(2);
    for (int i = 0; i < 3; i++) begin
      check("R1", "ref_tick with divide-by-1", ref_tick, 1);
      tick(1);
    end

    // acquisition: ref /2, loop /4, VCO 100 MHz -> 32 edges per window
    ctl_write(1'b0, 1'b1);
    vco_half = 5.0;
    expect_at(300, 1'b0, 1'b1, 1'b0, "R4 early");
    expect_at(440, 1'b1, 1'b1, 1'b1, "R4 R7 R10 locked");
    div_write(6'd1, 6'd1);
    drain();
    ref_interval(n); ref_interval(n);
    check("R1", "ref interval /2", n, 2);
    fb_ratio("R2", 4);
    pll_period("R3", 10);

    // post-divide via control write; lock unaffected
    ctl_write(1'b1, 1'b1);
    tick(10);
    pll_period("R3", 20);
    check("R8", "lock after control write", lock, 1);
    clear_irq();
    check("R7", "irq after clear", irq, 0);

    // hold band: about 31 edges per window
    vco_half = 5.0 * 32.0 / 31.0;
    expect_at(400, 1'b1, 1'b1, 1'b0, "R6 hold band");
    drain();
    vco_half = 5.0;
    tick(200);

    // far off: about 21 edges -> drop
    vco_half = 7.5;
    expect_at(160, 1'b0, 1'b1, 1'b1, "R5 R7 drop");
    drain();

    // relock with interrupt disabled
    clear_irq();
    ctl_write(1'b0, 1'b0);
    vco_half = 5.0;
    expect_at(450, 1'b1, 1'b1, 1'b0, "R7 disabled relock");
    drain();

    // divider write while locked
    ctl_write(1'b0, 1'b1);
    expect_at(2, 1'b0, 1'b0, 1'b0, "R8 immediate clear");
    expect_at(3, 1'b0, 1'b1, 1'b1, "R8 R7 clear irq");
    expect_at(300, 1'b0, 1'b0, 1'b0, "R8 requalify");
    expect_at(440, 1'b1, 1'b0, 1'b0, "R8 R4 relock");
    div_write(6'd1, 6'd1);
    drain();
    clear_irq();

    // ref /4, loop /2, VCO 25 MHz
    vco_half = 20.0;
    expect_at(600, 1'b0, 1'b0, 1'b0, "R4 slow ref early");
    expect_at(820, 1'b1, 1'b0, 1'b0, "R4 slow ref locked");
    div_write(6'd3, 6'd0);
    ref_interval(n); ref_interval(n);
    check("R1", "ref interval /4", n, 4);
    drain();
    fb_ratio("R2", 2);

    // mid-interval reference change
    while (!ref_tick) tick(1);
    ref_div = 6'd1; syn_div = 6'd0; div_wr = 1'b1;
    ref_interval(n);
    div_wr = 1'b0;
    check("R9", "interval in progress keeps old ratio", n, 4);
    ref_interval(n);
    check("R9", "following interval uses new ratio", n, 2);

    tick(20);
    done = 1;
    summary();
    $finish;
  end

endmodule